// File: doc/BRIEF.md
# Log/Linear PCM Companding Converter

This block translates audio samples between 8-bit logarithmic telephony codes and a 16-bit linear word. Both directions are available at once. One input register takes a log code and produces a linear result. A second input register takes a linear word and produces a log code. A single mode bit chooses µ-law or A-law for both paths.

The linear word is always left-aligned in 16 bits. In µ-law mode the top 14 bits carry the value. In A-law mode the top 13 bits carry it. The conversion logic is purely combinational between the input registers and the read port, so a result can be read on the cycle after its input is written. No sample clock paces the block, and writes may arrive at any rate.

Software reaches the block through a plain write/read register port. Address 0 holds the mode, address 1 the log input, address 2 the linear input, address 3 the log result and address 4 the linear result.

Top module: `compand_core`

## Requirements
- R1: After reset, the mode, log-input and linear-input registers read 0. The log result reads 0xFF and the linear result reads 0x8284 (µ-law expansion of code 0x00).
- R2: Bit 0 of the mode register selects the law: 0 is µ-law and 1 is A-law. Bits 15:1 of the mode register always read 0.
- R3: A result reflects a write to address 0, 1 or 2 from the cycle after that write. A read in the same cycle as the write returns the old result. Changing the mode re-converts both stored inputs without rewriting them.
- R4: µ-law expansion inverts the code and splits it into sign (bit 7), segment (bits 6:4) and step (bits 3:0). The magnitude is 4·(((2·step+33)·2^segment) − 33), negated when the sign is 1. Bits 1:0 of the result are 0.
- R5: A-law expansion XORs the code with 0x55 and splits it into sign (bit 7), segment (bits 6:4) and step (bits 3:0). The magnitude is 8·(2·step+1) for segment 0 and 8·(2·step+33)·2^(segment−1) otherwise. The result is negated when the sign bit is 0. Bits 2:0 of the result are 0.
- R6: µ-law compression works on bits 15:2 as a signed 14-bit value. It takes the magnitude, adds a bias of 33, and forms segment and step from the leading one. It then inverts all bits for positive inputs, or bits 6:0 for negative inputs. Bits 1:0 of the linear input have no effect. An input of zero gives 0xFF.
- R7: A-law compression works on bits 15:3 as a signed 13-bit value. Negative inputs use the one's complement for the magnitude. The segment and step are taken from the leading one. The result is XORed with 0xD5 for positive inputs or 0x55 for negative inputs. Bits 2:0 of the linear input have no effect. An input of zero gives 0xD5.
- R8: In µ-law mode, a 14-bit magnitude of 8158 or more compresses to the top code of its sign: 0x80 when positive and 0x00 when negative.
- R9: In A-law mode, the extreme linear inputs 0x7FF8 and 0x8000 compress to 0xAA and 0x2A.
- R10: Writes to addresses 3 to 7 change no register. Reads of addresses 5 to 7 return 0.
- R11: The two paths are independent. Writing the log input leaves the log result unchanged, and writing the linear input leaves the linear result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |

## Verification
A write and a read can land in the same cycle, and the case that matters most is a mode write together with a read of a result. The bench raises the mode write strobe and points the read address at the linear result in the same cycle. It expects the result of the old law before the edge and the result of the new law after it. The same overlap is also provoked between an input write and a read of the result on the other path, which must not move.

// File: rtl/compand_pkg.sv
package compand_pkg;

    localparam int LOG_W  = 8;
    localparam int LIN_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;

    localparam logic [ADDR_W-1:0] ADR_MODE     = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CODE_IN  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_WORD_IN  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CODE_OUT = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_WORD_OUT = 3'd4;

endpackage

// File: rtl/compand_mu_dec.sv
module compand_mu_dec
    import compand_pkg::*;
#(
    parameter int CODE_W = LOG_W,
    parameter int WORD_W = LIN_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [WORD_W-1:0] word
);
    localparam int BIAS_16 = 132;

    logic [CODE_W-1:0] inv;
    logic [2:0]        seg;
    logic [3:0]        step;
    logic [7:0]        base;
    logic [14:0]       scaled;

    always_comb begin
        inv    = ~code;
        seg    = inv[6:4];
        step   = inv[3:0];
        base   = {1'b0, step, 3'b000} + 8'(BIAS_16);
        scaled = {7'b0, base} << seg;
        if (inv[7]) begin
            word = WORD_W'(BIAS_16) - {1'b0, scaled};
        end else begin
            word = {1'b0, scaled} - WORD_W'(BIAS_16);
        end
    end
endmodule

// File: rtl/compand_a_dec.sv
module compand_a_dec
    import compand_pkg::*;
#(
    parameter int CODE_W = LOG_W,
    parameter int WORD_W = LIN_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [WORD_W-1:0] word
);
    logic [CODE_W-1:0] flip;
    logic [2:0]        seg;
    logic [3:0]        step;
    logic [8:0]        base;
    logic [14:0]       scaled;

    always_comb begin
        flip = code ^ 8'h55;
        seg  = flip[6:4];
        step = flip[3:0];
        base = {1'b0, step, 4'b0000} + ((seg == 3'd0) ? 9'd8 : 9'd264);
        if (seg == 3'd0) begin
            scaled = {6'b0, base};
        end else begin
            scaled = {6'b0, base} << (seg - 3'd1);
        end
        if (flip[7]) begin
            word = {1'b0, scaled};
        end else begin
            word = WORD_W'(0) - {1'b0, scaled};
        end
    end
endmodule

// File: rtl/compand_mu_enc.sv
module compand_mu_enc
    import compand_pkg::*;
#(
    parameter int CODE_W = LOG_W,
    parameter int WORD_W = LIN_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [CODE_W-1:0] code
);
    localparam int CLIP = 8158;
    localparam int BIAS = 33;

    logic [13:0] s14;
    logic [14:0] ext;
    logic [14:0] mag;
    logic [12:0] biased;
    logic [12:0] shifted;
    logic [2:0]  seg;
    logic [6:0]  packed_code;

    always_comb begin
        s14 = word[WORD_W-1 -: 14];
        ext = {s14[13], s14};
        mag = s14[13] ? (15'd0 - ext) : ext;
        if (mag > 15'(CLIP)) begin
            biased = 13'(CLIP + BIAS);
        end else begin
            biased = mag[12:0] + 13'(BIAS);
        end
        seg = 3'd0;
        for (int i = 6; i <= 12; i++) begin
            if (biased[i]) begin
                seg = 3'(i - 5);
            end
        end
        shifted     = biased >> ({1'b0, seg} + 4'd1);
        packed_code = {seg, shifted[3:0]};
        if (s14[13]) begin
            code = {1'b0, packed_code ^ 7'h7F};
        end else begin
            code = ~{1'b0, packed_code};
        end
    end
endmodule

// File: rtl/compand_a_enc.sv
module compand_a_enc
    import compand_pkg::*;
#(
    parameter int CODE_W = LOG_W,
    parameter int WORD_W = LIN_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [CODE_W-1:0] code
);
    logic [12:0] s13;
    logic [11:0] mag;
    logic [11:0] shifted;
    logic [2:0]  seg;

    always_comb begin
        s13 = word[WORD_W-1 -: 13];
        mag = s13[12] ? ~s13[11:0] : s13[11:0];
        seg = 3'd0;
        for (int i = 5; i <= 11; i++) begin
            if (mag[i]) begin
                seg = 3'(i - 4);
            end
        end
        shifted = mag >> ((seg == 3'd0) ? 3'd1 : seg);
        code    = {1'b0, seg, shifted[3:0]} ^ (s13[12] ? 8'h55 : 8'hD5);
    end
endmodule

// File: rtl/compand_core.sv
module compand_core
    import compand_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = LIN_W,
    parameter int CW = LOG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    law_e          mode_q;
    logic [CW-1:0] code_in_q;
    logic [DW-1:0] word_in_q;

    logic [DW-1:0] mu_word, a_word, word_out;
    logic [CW-1:0] mu_code, a_code, code_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= LAW_MU;
            code_in_q <= '0;
            word_in_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_MODE:    mode_q    <= law_e'(wr_data[0]);
                ADR_CODE_IN: code_in_q <= wr_data[CW-1:0];
                ADR_WORD_IN: word_in_q <= wr_data;
                default:     ;
            endcase
        end
    end

    compand_mu_dec #(.CODE_W(CW), .WORD_W(DW)) u_mu_dec (.code(code_in_q), .word(mu_word));
    compand_a_dec  #(.CODE_W(CW), .WORD_W(DW)) u_a_dec  (.code(code_in_q), .word(a_word));
    compand_mu_enc #(.CODE_W(CW), .WORD_W(DW)) u_mu_enc (.word(word_in_q), .code(mu_code));
    compand_a_enc  #(.CODE_W(CW), .WORD_W(DW)) u_a_enc  (.word(word_in_q), .code(a_code));

    always_comb begin
        word_out = (mode_q == LAW_A) ? a_word : mu_word;
        code_out = (mode_q == LAW_A) ? a_code : mu_code;
    end

    always_comb begin
        unique case (rd_addr)
            ADR_MODE:     rd_data = {{(DW-1){1'b0}}, mode_q};
            ADR_CODE_IN:  rd_data = {{(DW-CW){1'b0}}, code_in_q};
            ADR_WORD_IN:  rd_data = word_in_q;
            ADR_CODE_OUT: rd_data = {{(DW-CW){1'b0}}, code_out};
            ADR_WORD_OUT: rd_data = word_out;
            default:      rd_data = '0;
        endcase
    end

    AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADR_MODE) |-> (rd_data[DW-1:1] == '0)); // R2

    AST_MU_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LAW_MU) |-> (word_out[1:0] == 2'b00)); // R4

    AST_A_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LAW_A) |-> (word_out[2:0] == 3'b000)); // R5

    AST_MU_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LAW_MU && word_in_q[DW-1:2] == '0) |-> (code_out == 8'hFF)); // R6

    AST_A_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LAW_A && word_in_q[DW-1:3] == '0) |-> (code_out == 8'hD5)); // R7

    AST_MU_POS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LAW_MU && !word_in_q[DW-1] && word_in_q >= 16'h7F78) |-> (code_out == 8'h80)); // R8

    AST_OUT_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADR_WORD_IN) |=>
        ($stable(mode_q) && $stable(code_in_q) && $stable(word_in_q))); // R10
endmodule

// File: tb/sim_compand_core.sv
module sim_compand_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    compand_core u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    always #5 clk = ~clk;

    function automatic logic [15:0] ref_mu_dec(input logic [7:0] c);
        int u, e, m, mag;
        u = int'(~c);
        e = (u >> 4) & 7;
        m = u & 15;
        mag = (((2 * m + 33) << e) - 33) * 4;
        return (u & 128) != 0 ? 16'(-mag) : 16'(mag);
    endfunction

    function automatic logic [15:0] ref_a_dec(input logic [7:0] c);
        int a, s, m, mag;
        a = int'(c ^ 8'h55);
        s = (a >> 4) & 7;
        m = a & 15;
        mag = (s == 0) ? (2 * m + 1) * 8 : ((2 * m + 33) << (s - 1)) * 8;
        return (a & 128) != 0 ? 16'(mag) : 16'(-mag);
    endfunction

    function automatic logic [7:0] ref_mu_enc(input logic [15:0] w);
        int v, mag, b, s, m, c;
        v = int'($signed(w)) >>> 2;
        mag = (v < 0) ? -v : v;
        if (mag > 8158) mag = 8158;
        b = mag + 33;
        s = 0;
        while (s < 7 && b >= (64 << s)) s++;
        m = (b >> (s + 1)) & 15;
        c = s * 16 + m;
        return (v < 0) ? 8'(c ^ 127) : 8'(255 - c);
    endfunction

    function automatic logic [7:0] ref_a_enc(input logic [15:0] w);
        int v, mag, s, m, c;
        v = int'($signed(w)) >>> 3;
        mag = (v < 0) ? -v - 1 : v;
        s = 0;
        while (s < 7 && mag >= (32 << s)) s++;
        m = (mag >> ((s == 0) ? 1 : s)) & 15;
        c = s * 16 + m;
        return 8'(c ^ ((v < 0) ? 85 : 213));
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(3'd0, d); chk("R1 mode", d, 16'h0000);
        rd(3'd1, d); chk("R1 code_in", d, 16'h0000);
        rd(3'd2, d); chk("R1 word_in", d, 16'h0000);
        rd(3'd3, d); chk("R1 code_out", d, 16'h00FF);
        rd(3'd4, d); chk("R1 word_out", d, 16'h8284);
    endtask

    task automatic t_mode_reg;
        logic [15:0] d;
        wr(3'd0, 16'hFFFF); rd(3'd0, d); chk("R2 mode set", d, 16'h0001);
        wr(3'd0, 16'hFFFE); rd(3'd0, d); chk("R2 mode clear", d, 16'h0000);
    endtask

    task automatic t_expand(input bit alaw);
        logic [15:0] d;
        wr(3'd0, {15'd0, alaw});
        for (int c = 0; c < 256; c++) begin
            wr(3'd1, 16'(c));
            rd(3'd4, d);
            if (alaw) chk("R5 A-law expand", d, ref_a_dec(8'(c)));
            else      chk("R4 mu-law expand", d, ref_mu_dec(8'(c)));
        end
    endtask

    task automatic t_compress(input bit alaw);
        logic [15:0] d, d2;
        wr(3'd0, {15'd0, alaw});
        for (int v = 0; v < 65536; v += 61) begin
            wr(3'd2, 16'(v));
            rd(3'd3, d);
            if (alaw) chk("R7 A-law compress", d, {8'h00, ref_a_enc(16'(v))});
            else      chk("R6 mu-law compress", d, {8'h00, ref_mu_enc(16'(v))});
        end
        wr(3'd2, alaw ? 16'h1237 : 16'h1233); rd(3'd3, d);
        wr(3'd2, 16'h1230);                   rd(3'd3, d2);
        chk(alaw ? "R7 low bits ignored" : "R6 low bits ignored", d, d2);
        wr(3'd2, alaw ? 16'h0007 : 16'h0003); rd(3'd3, d);
        chk(alaw ? "R7 zero code" : "R6 zero code", d, alaw ? 16'h00D5 : 16'h00FF);
    endtask

    task automatic t_extremes;
        logic [15:0] d;
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h7FFC); rd(3'd3, d); chk("R8 mu pos top", d, 16'h0080);
        wr(3'd2, 16'h7F78); rd(3'd3, d); chk("R8 mu pos edge", d, 16'h0080);
        wr(3'd2, 16'h8000); rd(3'd3, d); chk("R8 mu neg top", d, 16'h0000);
        wr(3'd2, 16'h8088); rd(3'd3, d); chk("R8 mu neg edge", d, 16'h0000);
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'h7FF8); rd(3'd3, d); chk("R9 A pos top", d, 16'h00AA);
        wr(3'd2, 16'h8000); rd(3'd3, d); chk("R9 A neg top", d, 16'h002A);
    endtask

    task automatic t_ignored;
        logic [15:0] d;
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0042);
        wr(3'd2, 16'h0400);
        for (int a = 3; a < 8; a++) wr(3'(a), 16'hFFFF);
        rd(3'd0, d); chk("R10 mode kept", d, 16'h0000);
        rd(3'd1, d); chk("R10 code_in kept", d, 16'h0042);
        rd(3'd2, d); chk("R10 word_in kept", d, 16'h0400);
        rd(3'd3, d); chk("R10 code_out kept", d, {8'h00, ref_mu_enc(16'h0400)});
        rd(3'd4, d); chk("R10 word_out kept", d, ref_mu_dec(8'h42));
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d); chk("R10 unmapped read", d, 16'h0000);
        end
    endtask

    task automatic t_same_cycle;
        logic [15:0] d;
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0080);
        wr(3'd2, 16'hC000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0001;
        rd(3'd4, d); chk("R3 old law same cycle", d, ref_mu_dec(8'h80));
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd4, d); chk("R3 new law next cycle", d, ref_a_dec(8'h80));
        rd(3'd3, d); chk("R3 mode reconverts word_in", d, {8'h00, ref_a_enc(16'hC000)});
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0013;
        rd(3'd3, d); chk("R11 code_out during code_in write", d, {8'h00, ref_a_enc(16'hC000)});
        rd(3'd4, d); chk("R3 old word_out same cycle", d, ref_a_dec(8'h80));
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd4, d); chk("R3 new word_out next cycle", d, ref_a_dec(8'h13));
        rd(3'd3, d); chk("R11 code_out after code_in write", d, {8'h00, ref_a_enc(16'hC000)});
        wr(3'd2, 16'h2345);
        rd(3'd4, d); chk("R11 word_out after word_in write", d, ref_a_dec(8'h13));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_reg();
        t_expand(1'b0);
        t_expand(1'b1);
        t_compress(1'b0);
        t_compress(1'b1);
        t_extremes();
        t_ignored();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule